// File: doc/BRIEF.md
# Three-wire command and descriptor port

This block is a slave serial port built on three wires: an active-low select line that frames each word and latches it, a serial clock, and a data line. A controller shifts one 16-bit command word per frame. When the frame closes, the block decodes two mode bits in the word. The low byte then goes to one of two places:

- an 8-bit register of button states, which feeds the human-interface report logic; or
- a descriptor RAM, through an address counter that steps up by one after each write.

The serial wires are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the block then detects edges on the synchronized copies. The RAM sits outside the block and is written through a one-cycle strobe with address and data. A streaming session starts with an address-reset command. The session is complete once a fixed number of descriptor bytes has been written, and a done flag reports this.

Top module: `cmd_desc_port`

## Requirements
- R1: While reset is asserted, and after it is released, `btn_status` is 0x00, `ram_we` is low and `desc_done` is low, until a valid word arrives.
- R2: While `sel_n` is low, `sdata` is sampled on each rising edge of `sclk`. Bits are taken most significant first. The word is acted on only when `sel_n` returns high.
- R3: A word with bit 11 = 0 and bit 12 = 0 loads bits 7:0 into `btn_status` and writes no RAM byte. The bits of `btn_status` are active high: bit 7 mute, bit 6 volume up, bit 5 volume down, bit 4 next, bit 3 previous, bit 2 stop, bit 1 play/pause, bit 0 auxiliary.
- R4: A word with bit 11 = 0 and bit 12 = 1 loads `btn_status` as in R3. It also clears the address counter to 0, clears `desc_done`, and enables descriptor writes.
- R5: When descriptor writes are enabled and `desc_done` is low, a word with bit 11 = 1 and bit 12 = 0 gives a one-cycle `ram_we` pulse. During that pulse, `ram_addr` holds the counter value and `ram_wdata` holds word bits 7:0, with word bit 0 on `ram_wdata[0]`. The counter then increments.
- R6: `desc_done` rises in the same cycle as the write to address 56, which is the 57th byte. Descriptor words that arrive while `desc_done` is high are dropped.
- R7: Descriptor words that arrive before the first address reset after reset are dropped.
- R8: A word with bit 11 = 1 and bit 12 = 1 changes no output.
- R9: If `sel_n` rises after any number of `sclk` rising edges other than 16, the frame is discarded.
- R10: Rising edges of `sclk` while `sel_n` is high are ignored. Word bits 15:13 and 10:8 have no effect.
- R11: The edge of `clk` that first samples `sel_n` high is counted as edge 1. Outputs change at edge 3 and are unchanged after edges 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Frame select, low while a word is shifted; its rising edge latches the word |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| btn_status | output | 8 | Button state register |
| ram_we | output | 1 | One-cycle write strobe for the descriptor RAM |
| ram_addr | output | 6 | Descriptor RAM address, valid with `ram_we` |
| ram_wdata | output | 8 | Descriptor RAM data byte, valid with `ram_we` |
| desc_done | output | 1 | High once all 57 descriptor bytes have been written |

## Verification
A wrong bit count or a corrupted shift register appears on `btn_status` or `ram_wdata` at the third clock edge after the select line rises. A wrong address counter does not stay hidden: it shows on `ram_addr` at the next descriptor strobe. It also moves the rise of `desc_done` away from the write to address 56. The armed and done state has no output of its own. It shows only as strobes that appear or go missing on later descriptor words, so the bench probes it with words sent before an address reset, after the last byte, and after a second address reset.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  parameter int WORD_W     = 16;
  parameter int BYTE_W     = 8;
  parameter int DESC_BYTES = 57;
  parameter int ST_BIT     = 11;
  parameter int AD_BIT     = 12;
  localparam int SH_W   = AD_BIT + 1;
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam int ADDR_W = $clog2(DESC_BYTES + 1);
endpackage

// File: rtl/cdp_sync.sv
module cdp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/cdp_frame.sv
module cdp_frame
  import cdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_sel,
  input  logic              s_clk,
  input  logic              s_dat,
  output logic              word_vld,
  output logic              fld_st,
  output logic              fld_ad,
  output logic [BYTE_W-1:0] fld_byte
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic             prev_sel_q, prev_clk_q;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_fall, sel_rise, clk_rise;

  assign sel_fall = prev_sel_q & ~s_sel;
  assign sel_rise = ~prev_sel_q & s_sel;
  assign clk_rise = ~prev_clk_q & s_clk;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (sel_fall) begin
      cnt_d = '0;
    end else if (!s_sel && clk_rise) begin
      sh_d = {sh_q[SH_W-2:0], s_dat};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_q <= 1'b1;
      prev_clk_q <= 1'b0;
      sh_q       <= '0;
      cnt_q      <= '0;
    end else begin
      prev_sel_q <= s_sel;
      prev_clk_q <= s_clk;
      sh_q       <= sh_d;
      cnt_q      <= cnt_d;
    end
  end

  assign word_vld = sel_rise && (cnt_q == CNT_FULL);
  assign fld_st   = sh_q[ST_BIT];
  assign fld_ad   = sh_q[AD_BIT];
  assign fld_byte = sh_q[BYTE_W-1:0];
endmodule

// File: rtl/cdp_decode.sv
module cdp_decode
  import cdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic              fld_st,
  input  logic              fld_ad,
  input  logic [BYTE_W-1:0] fld_byte,
  output logic [BYTE_W-1:0] status_q,
  output logic              we_q,
  output logic [ADDR_W-1:0] waddr_q,
  output logic [BYTE_W-1:0] wdata_q,
  output logic              done_q
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DESC_BYTES - 1);

  logic [BYTE_W-1:0] status_d, wdata_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, waddr_d;
  logic              armed_q, armed_d, done_d, we_d;

  always_comb begin
    status_d = status_q;
    wdata_d  = wdata_q;
    waddr_d  = waddr_q;
    ptr_d    = ptr_q;
    armed_d  = armed_q;
    done_d   = done_q;
    we_d     = 1'b0;
    if (word_vld) begin
      if (!fld_st) begin
        status_d = fld_byte;
        if (fld_ad) begin
          ptr_d   = '0;
          armed_d = 1'b1;
          done_d  = 1'b0;
        end
      end else if (!fld_ad && armed_q && !done_q) begin
        we_d    = 1'b1;
        waddr_d = ptr_q;
        wdata_d = fld_byte;
        ptr_d   = ptr_q + 1'b1;
        if (ptr_q == LAST) done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      wdata_q  <= '0;
      waddr_q  <= '0;
      ptr_q    <= '0;
      armed_q  <= 1'b0;
      done_q   <= 1'b0;
      we_q     <= 1'b0;
    end else begin
      status_q <= status_d;
      wdata_q  <= wdata_d;
      waddr_q  <= waddr_d;
      ptr_q    <= ptr_d;
      armed_q  <= armed_d;
      done_q   <= done_d;
      we_q     <= we_d;
    end
  end
endmodule

// File: rtl/cmd_desc_port.sv
module cmd_desc_port
  import cdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdata,
  output logic [BYTE_W-1:0] btn_status,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              desc_done
);
  logic              rst_meta_q, rst_sync_n;
  logic [2:0]        pins_s;
  logic              word_vld, fld_st, fld_ad;
  logic [BYTE_W-1:0] fld_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cdp_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({sel_n, sclk, sdata}),
    .q     (pins_s)
  );

  cdp_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .s_sel    (pins_s[2]),
    .s_clk    (pins_s[1]),
    .s_dat    (pins_s[0]),
    .word_vld (word_vld),
    .fld_st   (fld_st),
    .fld_ad   (fld_ad),
    .fld_byte (fld_byte)
  );

  cdp_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .word_vld (word_vld),
    .fld_st   (fld_st),
    .fld_ad   (fld_ad),
    .fld_byte (fld_byte),
    .status_q (btn_status),
    .we_q     (ram_we),
    .waddr_q  (ram_addr),
    .wdata_q  (ram_wdata),
    .done_q   (desc_done)
  );
endmodule

// File: rtl/cdp_chk.sv
module cdp_chk
  import cdp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic [BYTE_W-1:0] btn_status,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              desc_done
);
  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr < ADDR_W'(DESC_BYTES)));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_done) |-> (ram_we && ram_addr == ADDR_W'(DESC_BYTES - 1)));

  // R6
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done && $past(desc_done)) |-> !ram_we);

  // R3
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(btn_status) |-> !ram_we);

  // R11
  status_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(btn_status) |-> $past(sel_n, 2));
endmodule

bind cmd_desc_port cdp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_n      (sel_n),
  .btn_status (btn_status),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .desc_done  (desc_done)
);

// File: tb/sim_cmd_desc_port.sv
`timescale 1ns/1ps
module sim_cmd_desc_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic [7:0] btn_status;
  logic       ram_we;
  logic [5:0] ram_addr;
  logic [7:0] ram_wdata;
  logic       desc_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmd_desc_port u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .btn_status(btn_status), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .desc_done(desc_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: the history of samples taken at each clk edge.
  bit h1_s = 1, h2_s = 1, h3_s = 1;
  bit h1_c = 0, h2_c = 0, h3_c = 0;
  bit h1_d = 0, h2_d = 0;
  bit bits_q[$];
  int m_status = 0, m_cnt = 0, m_addr = 0, m_data = 0;
  bit m_armed = 0, m_done = 0, m_we = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1_s = 1; h2_s = 1; h3_s = 1;
      h1_c = 0; h2_c = 0; h3_c = 0;
      h1_d = 0; h2_d = 0;
      bits_q.delete();
      m_status = 0; m_cnt = 0; m_armed = 0; m_done = 0; m_we = 0;
    end else begin
      m_we = 0;
      if (h3_s && !h2_s) begin
        bits_q.delete();
      end else if (!h2_s && !h3_c && h2_c) begin
        if (bits_q.size() < 40) bits_q.push_back(h2_d);
      end else if (!h3_s && h2_s) begin
        if (bits_q.size() == 16) begin
          int w = 0;
          foreach (bits_q[i]) w = (w << 1) | int'(bits_q[i]);
          if (((w >> 11) & 1) == 0) begin
            m_status = w & 255;
            if (((w >> 12) & 1) == 1) begin
              m_cnt = 0; m_armed = 1; m_done = 0;
            end
          end else if (((w >> 12) & 1) == 0 && m_armed && !m_done) begin
            m_we = 1; m_addr = m_cnt; m_data = w & 255;
            m_cnt++;
            if (m_cnt == 57) m_done = 1;
          end
        end
      end
      h3_s = h2_s; h2_s = h1_s; h1_s = sel_n;
      h3_c = h2_c; h2_c = h1_c; h1_c = sclk;
      h2_d = h1_d; h1_d = sdata;
    end
  end

  // Compare with the model every cycle and capture writes.
  int wr_seen = 0;
  int mem [0:63];
  always @(negedge clk) begin
    if (!finished) begin
      check(btn_status == 8'(m_status), "R3 status vs model", btn_status, m_status);
      check(ram_we == m_we, "R5 strobe vs model", ram_we, m_we);
      check(desc_done == m_done, "R6 done vs model", desc_done, m_done);
      if (ram_we) begin
        check(ram_addr == 6'(m_addr), "R5 addr vs model", ram_addr, m_addr);
        check(ram_wdata == 8'(m_data), "R5 data vs model", ram_wdata, m_data);
        mem[ram_addr] = ram_wdata;
        wr_seen++;
      end
    end
  end

  task automatic shift_bits(input logic [31:0] w, input int n);
    sel_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    shift_bits(w, n);
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    send_bits({16'h0, w}, 16);
  endtask

  function automatic logic [7:0] dbyte(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int wr0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(btn_status == 8'h00, "R1 status in reset", btn_status, 0);
    check(!ram_we && !desc_done, "R1 strobe/done in reset", {ram_we, desc_done}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(btn_status == 8'h00 && !desc_done, "R1 after release", btn_status, 0);

    // R2, R10: status word with junk in bits 15:13 and 10:8
    send_word(16'hE7A5);
    check(btn_status == 8'hA5, "R2 R10 status word", btn_status, 8'hA5);

    // R10: serial clock pulses while select high
    for (int i = 0; i < 20; i++) begin
      sdata = i[0];
      repeat (2) @(negedge clk); sclk = 1'b1;
      repeat (2) @(negedge clk); sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    check(btn_status == 8'hA5, "R10 clocks while deselected", btn_status, 8'hA5);
    send_word(16'h0081);
    check(btn_status == 8'h81, "R10 word after stray clocks", btn_status, 8'h81);

    // R7 descriptor words before any address reset
    wr0 = wr_seen;
    send_word(16'h0855);
    send_word(16'h0866);
    check(wr_seen == wr0, "R7 writes before arm", wr_seen, wr0);
    check(btn_status == 8'h81, "R7 status untouched", btn_status, 8'h81);

    // R9 short and long frames
    send_bits(32'h0000_00FF >> 1, 15);
    check(btn_status == 8'h81, "R9 15-bit frame", btn_status, 8'h81);
    send_bits(32'h0000_00FF, 17);
    check(btn_status == 8'h81, "R9 17-bit frame", btn_status, 8'h81);

    // R11 latency of the latch
    shift_bits(32'h0000_005A, 16);
    sel_n = 1'b1;
    @(negedge clk);
    check(btn_status == 8'h81, "R11 after edge 1", btn_status, 8'h81);
    @(negedge clk);
    check(btn_status == 8'h81, "R11 after edge 2", btn_status, 8'h81);
    @(negedge clk);
    check(btn_status == 8'h5A, "R11 after edge 3", btn_status, 8'h5A);
    repeat (6) @(negedge clk);

    // R4 address reset combined with status
    send_word(16'h103C);
    check(btn_status == 8'h3C, "R4 status with address reset", btn_status, 8'h3C);

    // R8 reserved combination
    wr0 = wr_seen;
    send_word(16'h18C3);
    check(wr_seen == wr0 && btn_status == 8'h3C, "R8 reserved word", wr_seen, wr0);

    // R5 R6 stream the full descriptor
    wr0 = wr_seen;
    for (int i = 0; i < 57; i++) begin
      send_word({8'h08, dbyte(i)});
      if (i == 55) check(!desc_done, "R6 done before last byte", desc_done, 0);
    end
    check(wr_seen - wr0 == 57, "R5 write count", wr_seen - wr0, 57);
    check(desc_done, "R6 done after 57 bytes", desc_done, 1);
    for (int i = 0; i < 57; i++)
      check(mem[i] == int'(dbyte(i)), "R5 byte placement", mem[i], dbyte(i));

    // R6 extra byte dropped
    wr0 = wr_seen;
    send_word(16'h08EE);
    check(wr_seen == wr0, "R6 byte after done", wr_seen, wr0);

    // R4 second address reset re-arms and restarts at 0
    send_word(16'h1000);
    check(!desc_done && btn_status == 8'h00, "R4 done cleared", desc_done, 0);
    for (int i = 0; i < 3; i++) send_word({8'h08, 8'(8'h90 + i)});
    check(wr_seen == wr0 + 3, "R4 restart writes", wr_seen, wr0 + 3);
    check(mem[0] == 8'h90 && mem[2] == 8'h92, "R4 restart addresses", mem[2], 8'h92);
    check(!desc_done, "R6 done low mid-stream", desc_done, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule